// File: doc/BRIEF.md
# Receive FIFO with Hysteretic RTS

This block buffers received bytes between a UART deserializer and a 32-bit register read port. Each valid strobe from the deserializer pushes one byte. A read pops either one byte or, in multiple-data mode, up to four packed bytes. A ready request tells the consumer that data is waiting. A byte that arrives while the FIFO is full is dropped, and the drop is recorded in a sticky overrun flag.

The request-to-send output `rts_o` is a flow-control line: high means "stop" and low means "send". The block moves it automatically only when occupancy crosses one of two programmable thresholds. Falling to or below the low mark releases the peer. Rising to or above the high mark holds the peer off. Between the marks the line keeps its last value. Software may also force the line either way with one-cycle strobes, and these work whether or not the automatic control is enabled.

Top module: `rx_fifo_rts`

## Requirements
- R1: Bytes leave in arrival order. A read with `rd_word_i`=0 pops one byte and presents it in `rd_data_o[7:0]`, with bits 31:8 zero.
- R2: With `multi_mode_i`=1 and `rd_word_i`=1, a read pops four bytes. The oldest byte is in bits 7:0, then 15:8, then 23:16, and the newest of the four is in bits 31:24.
- R3: A multiple-data word read with fewer than four bytes stored returns zero in the lanes that have no byte and leaves the FIFO empty. A read of an empty FIFO returns zero and changes nothing.
- R4: With `multi_mode_i`=0, a read with `rd_word_i`=1 pops a single byte in bits 7:0, with bits 31:8 zero.
- R5: `rx_ready_o` is high exactly when at least one byte is stored.
- R6: A byte arriving while `level_o` equals DEPTH is discarded and sets `overrun_o`. The flag stays set until a cycle with `ovr_clr_i` high and no new overrun.
- R7: With `auto_rts_en_i`=1, an update that takes occupancy from below `thr_hi_i` to `thr_hi_i` or above drives `rts_o` high on that clock edge.
- R8: With `auto_rts_en_i`=1, an update that takes occupancy from above `thr_lo_i` to `thr_lo_i` or below drives `rts_o` low on that clock edge.
- R9: `rts_o` resets high. When no strobe is applied and no threshold is crossed, it holds its value.
- R10: With `auto_rts_en_i`=0, threshold crossings have no effect on `rts_o`.
- R11: `rts_go_i` drives `rts_o` low and `rts_stop_i` drives it high on the next edge. Both override a threshold crossing in the same cycle, and `rts_stop_i` wins if both strobes are high.
- R12: `level_o` reports the stored byte count. A push and a pop in the same cycle change it by (pushes minus pops).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Deserializer byte strobe |
| rx_data_i | input | 8 | Received byte |
| rd_en_i | input | 1 | Read pop request |
| rd_word_i | input | 1 | Access size: 0 byte, 1 word |
| multi_mode_i | input | 1 | 1 = word read drains four bytes |
| rd_data_o | output | 32 | Read data, valid while rd_en_i is high |
| thr_lo_i | input | CW | Low occupancy threshold |
| thr_hi_i | input | CW | High occupancy threshold |
| auto_rts_en_i | input | 1 | Enable threshold-driven RTS |
| rts_go_i | input | 1 | Strobe: drive RTS low |
| rts_stop_i | input | 1 | Strobe: drive RTS high |
| ovr_clr_i | input | 1 | Clear the overrun flag |
| rts_o | output | 1 | Request-to-send, high means stop |
| rx_ready_o | output | 1 | At least one byte stored |
| overrun_o | output | 1 | Sticky overrun flag |
| level_o | output | CW | Stored byte count |

## Verification
The assertions take it for granted that `thr_lo_i` ≤ `thr_hi_i` and that both thresholds stay constant while the automatic control is enabled. Under that assumption, a crossing is defined by the reported level from one cycle to the next. The stimulus sets the thresholds only while `auto_rts_en_i` is low and keeps the low mark under the high mark. The strobes last one cycle each, and reads are issued at the full range of occupancies, including empty and full.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = 4;
  localparam int unsigned WORD_W = BYTE_W * LANES;
  typedef enum logic {
    ACC_BYTE = 1'b0,
    ACC_WORD = 1'b1
  } acc_size_e;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic [rxf_pkg::BYTE_W-1:0] data_i,
  input  logic [2:0]                 pop_cnt_i,
  output logic [rxf_pkg::WORD_W-1:0] peek_o,
  output logic [CW-1:0]              level_o
);
  logic [rxf_pkg::BYTE_W-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] level_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + AW'(1);
      rd_ptr_q <= rd_ptr_q + AW'(pop_cnt_i);
      level_q  <= level_q - CW'(pop_cnt_i) + CW'(push_i);
    end
  end

  // show-ahead lanes, zero where no byte is stored
  for (genvar k = 0; k < rxf_pkg::LANES; k++) begin : g_lane
    logic [AW-1:0] idx;
    assign idx = rd_ptr_q + AW'(k);
    assign peek_o[k*rxf_pkg::BYTE_W +: rxf_pkg::BYTE_W] =
      (level_q > CW'(k)) ? mem_q[idx] : '0;
  end

  assign level_o = level_q;
endmodule

// File: rtl/rxf_read_ctl.sv
module rxf_read_ctl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic                       rd_en_i,
  input  logic                       rd_word_i,
  input  logic                       multi_mode_i,
  input  logic [CW-1:0]              level_i,
  input  logic [rxf_pkg::WORD_W-1:0] peek_i,
  output logic [2:0]                 pop_cnt_o,
  output logic [rxf_pkg::WORD_W-1:0] rd_data_o
);
  import rxf_pkg::*;
  acc_size_e acc;
  logic      wide;

  assign acc  = acc_size_e'(rd_word_i);
  assign wide = (acc == ACC_WORD) && multi_mode_i;

  always_comb begin
    pop_cnt_o = '0;
    if (wide) begin
      rd_data_o = peek_i;
      if (rd_en_i) pop_cnt_o = (level_i >= CW'(LANES)) ? 3'(LANES) : 3'(level_i);
    end else begin
      rd_data_o = {{(WORD_W - BYTE_W){1'b0}}, peek_i[BYTE_W-1:0]};
      if (rd_en_i && level_i != '0) pop_cnt_o = 3'd1;
    end
  end
endmodule

// File: rtl/rxf_rts_ctl.sv
module rxf_rts_ctl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] level_q_i,
  input  logic [CW-1:0] level_d_i,
  input  logic [CW-1:0] thr_lo_i,
  input  logic [CW-1:0] thr_hi_i,
  input  logic          auto_en_i,
  input  logic          go_i,
  input  logic          stop_i,
  output logic          rts_o
);
  logic cross_up, cross_dn, rts_d, rts_q;

  assign cross_up = (level_q_i < thr_hi_i) && (level_d_i >= thr_hi_i);
  assign cross_dn = (level_q_i > thr_lo_i) && (level_d_i <= thr_lo_i);

  always_comb begin
    rts_d = rts_q;
    if (stop_i)                       rts_d = 1'b1;
    else if (go_i)                    rts_d = 1'b0;
    else if (auto_en_i && cross_up)   rts_d = 1'b1;
    else if (auto_en_i && cross_dn)   rts_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rts_q <= 1'b1;
    else         rts_q <= rts_d;
  end

  assign rts_o = rts_q;
endmodule

// File: rtl/rx_fifo_rts.sv
module rx_fifo_rts #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  input  logic          rd_en_i,
  input  logic          rd_word_i,
  input  logic          multi_mode_i,
  output logic [31:0]   rd_data_o,
  input  logic [CW-1:0] thr_lo_i,
  input  logic [CW-1:0] thr_hi_i,
  input  logic          auto_rts_en_i,
  input  logic          rts_go_i,
  input  logic          rts_stop_i,
  input  logic          ovr_clr_i,
  output logic          rts_o,
  output logic          rx_ready_o,
  output logic          overrun_o,
  output logic [CW-1:0] level_o
);
  logic [CW-1:0] level_q, level_d;
  logic [31:0]   peek;
  logic [2:0]    pop_cnt;
  logic          full, push, ovr_q;

  assign full    = (level_q == CW'(DEPTH));
  assign push    = rx_valid_i && !full;
  assign level_d = level_q - CW'(pop_cnt) + CW'(push);

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (push),
    .data_i    (rx_data_i),
    .pop_cnt_i (pop_cnt),
    .peek_o    (peek),
    .level_o   (level_q)
  );

  rxf_read_ctl #(.DEPTH(DEPTH)) u_read (
    .rd_en_i      (rd_en_i),
    .rd_word_i    (rd_word_i),
    .multi_mode_i (multi_mode_i),
    .level_i      (level_q),
    .peek_i       (peek),
    .pop_cnt_o    (pop_cnt),
    .rd_data_o    (rd_data_o)
  );

  rxf_rts_ctl #(.DEPTH(DEPTH)) u_rts (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_q_i (level_q),
    .level_d_i (level_d),
    .thr_lo_i  (thr_lo_i),
    .thr_hi_i  (thr_hi_i),
    .auto_en_i (auto_rts_en_i),
    .go_i      (rts_go_i),
    .stop_i    (rts_stop_i),
    .rts_o     (rts_o)
  );

  // new overrun wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ovr_q <= 1'b0;
    else if (rx_valid_i && full) ovr_q <= 1'b1;
    else if (ovr_clr_i)          ovr_q <= 1'b0;
  end

  assign overrun_o  = ovr_q;
  assign rx_ready_o = (level_q != '0);
  assign level_o    = level_q;
endmodule

// File: rtl/rxf_rts_checker.sv
module rxf_rts_checker #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_valid_i,
  input logic          rd_en_i,
  input logic          rd_word_i,
  input logic          multi_mode_i,
  input logic [CW-1:0] thr_lo_i,
  input logic [CW-1:0] thr_hi_i,
  input logic          auto_rts_en_i,
  input logic          rts_go_i,
  input logic          rts_stop_i,
  input logic          ovr_clr_i,
  input logic          rts_o,
  input logic          rx_ready_o,
  input logic          overrun_o,
  input logic [CW-1:0] level_o
);
  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= CW'(DEPTH)); // R12
  AST_WORD_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && rd_word_i && multi_mode_i && !rx_valid_i && level_o >= CW'(4)
    |=> level_o == $past(level_o) - CW'(4)); // R2
  AST_READY_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !rd_en_i |=> rx_ready_o); // R5
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && level_o == CW'(DEPTH) |=> overrun_o && level_o == $past(level_o) - (rd_en_i ? level_o - level_o + (CW'(DEPTH) - level_o) : '0) || overrun_o); // R6
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o && !ovr_clr_i |=> overrun_o); // R6
  AST_RTS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(auto_rts_en_i && !rts_go_i && !rts_stop_i) &&
    $past(level_o) < thr_hi_i && level_o >= thr_hi_i |-> rts_o); // R7
  AST_RTS_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(auto_rts_en_i && !rts_go_i && !rts_stop_i) &&
    $past(level_o) > thr_lo_i && level_o <= thr_lo_i |-> !rts_o); // R8
  AST_RTS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rts_go_i && !rts_stop_i) && level_o > thr_lo_i && level_o < thr_hi_i
    |-> rts_o == $past(rts_o)); // R9
  AST_RTS_MANUAL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_rts_en_i && !rts_go_i && !rts_stop_i |=> $stable(rts_o)); // R10
  AST_RTS_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rts_stop_i |=> rts_o); // R11
  AST_RTS_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rts_go_i && !rts_stop_i |=> !rts_o); // R11
endmodule

bind rx_fifo_rts rxf_rts_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rx_valid_i    (rx_valid_i),
  .rd_en_i       (rd_en_i),
  .rd_word_i     (rd_word_i),
  .multi_mode_i  (multi_mode_i),
  .thr_lo_i      (thr_lo_i),
  .thr_hi_i      (thr_hi_i),
  .auto_rts_en_i (auto_rts_en_i),
  .rts_go_i      (rts_go_i),
  .rts_stop_i    (rts_stop_i),
  .ovr_clr_i     (ovr_clr_i),
  .rts_o         (rts_o),
  .rx_ready_o    (rx_ready_o),
  .overrun_o     (overrun_o),
  .level_o       (level_o)
);

// File: tb/rx_fifo_rts_test.sv
module rx_fifo_rts_test;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned NV = 11;
  // {valid, byte, rd_en, rd_word, expected rd_data, expected level after edge}
  localparam logic [47:0] VEC [NV] = '{
    {1'b1, 8'h11, 1'b0, 1'b0, 32'h0,        5'd1},
    {1'b1, 8'h22, 1'b0, 1'b0, 32'h0,        5'd2},
    {1'b1, 8'h33, 1'b0, 1'b0, 32'h0,        5'd3},
    {1'b1, 8'h44, 1'b0, 1'b0, 32'h0,        5'd4},
    {1'b1, 8'h55, 1'b0, 1'b0, 32'h0,        5'd5},
    {1'b0, 8'h00, 1'b1, 1'b1, 32'h44332211, 5'd1},
    {1'b0, 8'h00, 1'b1, 1'b0, 32'h00000055, 5'd0},
    {1'b1, 8'hA1, 1'b0, 1'b0, 32'h0,        5'd1},
    {1'b1, 8'hA2, 1'b1, 1'b0, 32'h000000A1, 5'd1},
    {1'b0, 8'h00, 1'b1, 1'b1, 32'h000000A2, 5'd0},
    {1'b0, 8'h00, 1'b1, 1'b0, 32'h00000000, 5'd0}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic rx_valid_i = 1'b0, rd_en_i = 1'b0, rd_word_i = 1'b0, multi_mode_i = 1'b1;
  logic [7:0] rx_data_i = '0;
  logic [CW-1:0] thr_lo_i = '0, thr_hi_i = CW'(DEPTH);
  logic auto_rts_en_i = 1'b0, rts_go_i = 1'b0, rts_stop_i = 1'b0, ovr_clr_i = 1'b0;
  logic [31:0] rd_data_o, rd_seen;
  logic rts_o, rx_ready_o, overrun_o;
  logic [CW-1:0] level_o;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  rx_fifo_rts #(.DEPTH(DEPTH)) uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [7:0] d, input logic rd, input logic w,
                     input logic go, input logic stop, input logic clr);
    @(negedge clk_i);
    rx_valid_i = v; rx_data_i = d; rd_en_i = rd; rd_word_i = w;
    rts_go_i = go; rts_stop_i = stop; ovr_clr_i = clr;
    #2 rd_seen = rd_data_o;
    @(posedge clk_i);
    #2;
    rx_valid_i = 1'b0; rd_en_i = 1'b0; rts_go_i = 1'b0; rts_stop_i = 1'b0; ovr_clr_i = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    cyc(1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    #35 rst_ni = 1'b1;
    #10;
    chk("R9 reset rts", 32'(rts_o), 32'd1);
    chk("R5 reset ready", 32'(rx_ready_o), 32'd0);
    chk("R6 reset overrun", 32'(overrun_o), 32'd0);
    chk("R12 reset level", 32'(level_o), 32'd0);

    // table: R1 R2 R3 R5 R12
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][47], VEC[i][46:39], VEC[i][38], VEC[i][37], 1'b0, 1'b0, 1'b0);
      if (VEC[i][38]) chk($sformatf("R1/R2/R3 vec%0d data", i), rd_seen, VEC[i][36:5]);
      chk($sformatf("R12 vec%0d level", i), 32'(level_o), 32'(VEC[i][4:0]));
      chk($sformatf("R5 vec%0d ready", i), 32'(rx_ready_o), 32'(VEC[i][4:0] != 0));
    end

    // R4 single-data mode
    multi_mode_i = 1'b0;
    push(8'hC1); push(8'hC2);
    cyc(1'b0, 8'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R4 single word data", rd_seen, 32'h000000C1);
    chk("R4 single word level", 32'(level_o), 32'd1);
    cyc(1'b0, 8'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R4 single word second", rd_seen, 32'h000000C2);
    multi_mode_i = 1'b1;

    // R6 overrun
    for (int i = 0; i < DEPTH; i++) push(8'(8'h40 + i));
    chk("R6 full level", 32'(level_o), 32'(DEPTH));
    chk("R6 no overrun yet", 32'(overrun_o), 32'd0);
    push(8'hEE);
    chk("R6 overrun set", 32'(overrun_o), 32'd1);
    chk("R6 level kept", 32'(level_o), 32'(DEPTH));
    for (int i = 0; i < 3; i++) cyc(1'b0, 8'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R6 sticky", 32'(overrun_o), 32'd1);
    cyc(1'b0, 8'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R6 last word drops extra byte", rd_seen, 32'h4F4E4D4C);
    chk("R6 drained", 32'(level_o), 32'd0);
    cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R6 cleared", 32'(overrun_o), 32'd0);

    // RTS hysteresis, lo=2 hi=6
    thr_lo_i = CW'(2); thr_hi_i = CW'(6);
    auto_rts_en_i = 1'b1;
    cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R11 go strobe", 32'(rts_o), 32'd0);
    for (int i = 0; i < 5; i++) push(8'(i));
    chk("R9 below high holds", 32'(rts_o), 32'd0);
    push(8'h05);
    chk("R7 rise at high", 32'(rts_o), 32'd1);
    cyc(1'b0, 8'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 between holds high", 32'(rts_o), 32'd1);
    cyc(1'b0, 8'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 8'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 level 3 still high", 32'(rts_o), 32'd1);
    cyc(1'b0, 8'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 fall at low", 32'(rts_o), 32'd0);
    chk("R12 level 2", 32'(level_o), 32'd2);
    cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R11 stop strobe", 32'(rts_o), 32'd1);
    push(8'h10);
    chk("R9 no crossing keeps stop", 32'(rts_o), 32'd1);

    // R10 auto disabled
    auto_rts_en_i = 1'b0;
    cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) push(8'(i));
    chk("R10 level 7", 32'(level_o), 32'd7);
    chk("R10 rise ignored", 32'(rts_o), 32'd0);
    cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 8'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 8'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R10 fall ignored", 32'(rts_o), 32'd1);
    chk("R3 empty after short word", 32'(level_o), 32'd0);

    // R11 precedence over a crossing, and stop over go
    auto_rts_en_i = 1'b1;
    cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) push(8'(i));
    cyc(1'b1, 8'h77, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R11 go beats rise", 32'(rts_o), 32'd0);
    chk("R12 level 6", 32'(level_o), 32'd6);
    cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R11 stop wins", 32'(rts_o), 32'd1);

    finish_run();
  end
endmodule